// File: doc/BRIEF.md
# DES Round Key Generator

This block turns one 64-bit DES key into the sixteen 48-bit round keys that a DES datapath uses, one key per request. When a key is loaded, the eight parity bits are dropped. The remaining 56 bits are split into two 28-bit halves, and each half is held in its own register.

Each accepted advance strobe rotates both halves in place by the amount scheduled for that round. The compression permutation then maps the rotated halves to a 48-bit round key, which is registered and presented on a valid/ready output. No table of sixteen keys is stored. In decrypt mode the halves are walked backward with right rotations, so the keys come out from round 16 down to round 1.

Key load follows valid/ready rules. A key is taken on any cycle where `key_valid` and `key_ready` are both high. `key_ready` goes low while a presented round key is still waiting for the consumer (`rk_valid` high, `rk_ready` low). The round key output holds its value under back-pressure. The advance strobe `step` is a plain control pin. A strobe is dropped if it arrives during back-pressure, after all sixteen rounds, before any key has been loaded, or in the same cycle as a key load.

Top module: `des_round_key_gen`

## Requirements
- R1: The parity bits `key_data[0]`, `key_data[8]`, ... `key_data[56]` (bit 0 of each byte) have no effect on any round key produced.
- R2: In encrypt mode (`key_decrypt`=0 at load), successive accepted steps present round keys 1 through 16. `rk_round` reports the round number minus one (0 through 15). For key 133457799BBCDFF1, round 1 gives 1B02EFFC7072 and round 2 gives 79AED9DBC9E5.
- R3: Round r uses both halves left-rotated by the sum of the first r entries of the shift list 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1, and then compressed. Each half counts its bits from the MSB of the 56-bit value.
- R4: In decrypt mode (`key_decrypt`=1 at load), accepted steps present round keys 16 down to 1, with `rk_round` going from 15 down to 0. For key 133457799BBCDFF1, the first key is CB3D8B0E17F5.
- R5: `rk_valid` is high on the clock after an accepted step, with the new key on `rk_data`.
- R6: While `rk_valid` is high and `rk_ready` is low, `rk_data` and `rk_round` hold and `key_ready` is low. A step given during that time is ignored and does not advance the round.
- R7: Once sixteen round keys have been produced, and before any key has been loaded since reset, steps are ignored and `rk_valid` stays low.
- R8: An accepted key load clears `rk_valid` on the next clock and restarts the sequence at its first round. This drops any progress made with the previous key.
- R9: After reset, `rk_valid` is low and `key_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Key offered on `key_data` |
| key_ready | output | 1 | Key can be taken this cycle |
| key_data | input | 64 | DES key, parity bit in bit 0 of each byte |
| key_decrypt | input | 1 | Sampled with the key: 1 walks rounds backward |
| step | input | 1 | Advance strobe: produce the next round key |
| rk_valid | output | 1 | Round key presented |
| rk_ready | input | 1 | Consumer takes the presented round key |
| rk_data | output | 48 | Round key |
| rk_round | output | 4 | Round number of `rk_data` minus one |

## Verification
Assertions check four things on every cycle:
- the one-cycle latency from an accepted step to `rk_valid`;
- that the output holds under back-pressure;
- that the round count stays stopped after sixteen rounds;
- that a key load restarts the count, and that `rk_round` moves up by one per step in encrypt mode and down by one in decrypt mode.

Only the bench's scenarios can show that the key values are correct. These checks include the published vectors, a bit-level model of the schedule in both directions, the parity-bit invariance, and that a step dropped under back-pressure does not skip a round.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
  localparam int KEY_W  = 64;
  localparam int HALF_W = 28;
  localparam int CD_W   = 2 * HALF_W;
  localparam int RK_W   = 48;
  localparam int ROUNDS = 16;
  localparam int CNT_W  = $clog2(ROUNDS + 1);
  localparam int IDX_W  = $clog2(ROUNDS);

  // Source key bit (1 = MSB) feeding each bit of the 56-bit value, MSB first.
  localparam int PC1_TAB [CD_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  // Bit of the rotated 56-bit value (1 = MSB) feeding each round-key bit.
  localparam int PC2_TAB [RK_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // Rotation for 0-based round index: one place on rounds 1, 2, 9, 16.
  function automatic logic [1:0] shift_of(input logic [IDX_W-1:0] idx);
    return (idx == 0 || idx == 1 || idx == 8 || idx == IDX_W'(ROUNDS - 1)) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/des_pc1.sv
module des_pc1
  import des_ks_pkg::*;
(
  input  logic [KEY_W-1:0]  key,
  output logic [HALF_W-1:0] c_half,
  output logic [HALF_W-1:0] d_half
);
  logic [CD_W-1:0] cd;

  always_comb begin
    cd = '0;
    for (int i = 0; i < CD_W; i++)
      cd[6'(CD_W - 1 - i)] = key[6'(KEY_W - PC1_TAB[i])];
  end

  assign c_half = cd[CD_W-1:HALF_W];
  assign d_half = cd[HALF_W-1:0];
endmodule

// File: rtl/des_half_rot.sv
module des_half_rot #(
  parameter int W = 28
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   amt,
  input  logic         to_right,
  output logic [W-1:0] dout
);
  always_comb begin
    unique case ({to_right, amt})
      3'b001:  dout = {din[W-2:0], din[W-1]};
      3'b010:  dout = {din[W-3:0], din[W-1:W-2]};
      3'b101:  dout = {din[0], din[W-1:1]};
      3'b110:  dout = {din[1:0], din[W-1:2]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/des_pc2.sv
module des_pc2
  import des_ks_pkg::*;
(
  input  logic [HALF_W-1:0] c_half,
  input  logic [HALF_W-1:0] d_half,
  output logic [RK_W-1:0]   rk
);
  logic [CD_W-1:0] cd;
  assign cd = {c_half, d_half};

  always_comb begin
    rk = '0;
    for (int i = 0; i < RK_W; i++)
      rk[6'(RK_W - 1 - i)] = cd[6'(CD_W - PC2_TAB[i])];
  end
endmodule

// File: rtl/des_round_key_gen.sv
module des_round_key_gen
  import des_ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [KEY_W-1:0]  key_data,
  input  logic              key_decrypt,
  input  logic              step,
  output logic              rk_valid,
  input  logic              rk_ready,
  output logic [RK_W-1:0]   rk_data,
  output logic [IDX_W-1:0]  rk_round
);
  localparam logic [CNT_W-1:0] DONE = CNT_W'(ROUNDS);

  logic [HALF_W-1:0] half_q   [2];
  logic [HALF_W-1:0] half_new [2];
  logic [HALF_W-1:0] half_rot [2];
  logic [CNT_W-1:0]  cnt_q;
  logic              dec_q;
  logic              rk_valid_q;
  logic [RK_W-1:0]   rk_q;
  logic [IDX_W-1:0]  round_q;

  logic              hold, key_fire, step_ok;
  logic [IDX_W-1:0]  sched_idx, round_nxt;
  logic [1:0]        amt;
  logic [RK_W-1:0]   rk_nxt;

  assign hold      = rk_valid_q && !rk_ready;
  assign key_ready = !hold;
  assign key_fire  = key_valid && key_ready;
  assign step_ok   = step && !key_fire && !hold && (cnt_q != DONE);

  // Encrypt uses the shift of the round being made; decrypt undoes the
  // shift of the round just presented (none before round 16).
  assign sched_idx = dec_q ? IDX_W'(CNT_W'(ROUNDS) - cnt_q) : cnt_q[IDX_W-1:0];
  assign amt       = (dec_q && cnt_q == '0) ? 2'd0 : shift_of(sched_idx);
  assign round_nxt = dec_q ? IDX_W'(CNT_W'(ROUNDS - 1) - cnt_q) : cnt_q[IDX_W-1:0];

  des_pc1 u_pc1 (
    .key    (key_data),
    .c_half (half_new[0]),
    .d_half (half_new[1])
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    des_half_rot #(.W(HALF_W)) u_rot (
      .din      (half_q[h]),
      .amt      (amt),
      .to_right (dec_q),
      .dout     (half_rot[h])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        half_q[h] <= '0;
      else if (key_fire) half_q[h] <= half_new[h];
      else if (step_ok)  half_q[h] <= half_rot[h];
    end
  end

  des_pc2 u_pc2 (
    .c_half (half_rot[0]),
    .d_half (half_rot[1]),
    .rk     (rk_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= DONE;
      dec_q      <= 1'b0;
      rk_valid_q <= 1'b0;
      rk_q       <= '0;
      round_q    <= '0;
    end else if (key_fire) begin
      cnt_q      <= '0;
      dec_q      <= key_decrypt;
      rk_valid_q <= 1'b0;
    end else if (step_ok) begin
      cnt_q      <= cnt_q + 1'b1;
      rk_valid_q <= 1'b1;
      rk_q       <= rk_nxt;
      round_q    <= round_nxt;
    end else if (rk_ready) begin
      rk_valid_q <= 1'b0;
    end
  end

  assign rk_valid = rk_valid_q;
  assign rk_data  = rk_q;
  assign rk_round = round_q;

  // R5: an accepted step is answered on the next clock
  p_valid_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok |=> rk_valid);

  // R6: the presented key holds under back-pressure
  p_hold_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid && !rk_ready) |=> (rk_valid && $stable(rk_data) && $stable(rk_round)));

  // R7: exhausted schedule stays exhausted until a key arrives
  p_stop_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == DONE && !key_fire) |=> (cnt_q == DONE && !$rose(rk_valid)));

  // R8: a key load restarts the sequence
  p_load_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_fire |=> (cnt_q == '0 && !rk_valid));

  // R2: encrypt rounds climb by one
  p_enc_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !dec_q && cnt_q != '0) |=> (rk_round == $past(rk_round) + 1'b1));

  // R4: decrypt rounds fall by one
  p_dec_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && dec_q && cnt_q != '0) |=> (rk_round == $past(rk_round) - 1'b1));
endmodule

// File: tb/des_round_key_gen_test.sv
module des_round_key_gen_test;
  localparam int CLK_PERIOD = 10;

  localparam int PC1_B [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};
  localparam int PC2_B [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};
  localparam int SCH_B [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_valid = 1'b0;
  logic        key_ready;
  logic [63:0] key_data = '0;
  logic        key_decrypt = 1'b0;
  logic        step = 1'b0;
  logic        rk_valid;
  logic        rk_ready = 1'b1;
  logic [47:0] rk_data;
  logic [3:0]  rk_round;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  des_round_key_gen uut (
    .clk, .rst_n, .key_valid, .key_ready, .key_data, .key_decrypt,
    .step, .rk_valid, .rk_ready, .rk_data, .rk_round
  );

  // Round key r (1..16) from whole-key cumulative rotation.
  function automatic logic [47:0] ref_rk(input logic [63:0] k, input int r);
    logic [55:0] cd;
    logic [27:0] c, d;
    logic [47:0] o;
    int tot = 0;
    for (int i = 0; i < 56; i++) cd[55 - i] = k[64 - PC1_B[i]];
    c = cd[55:28];
    d = cd[27:0];
    for (int j = 0; j < r; j++) tot += SCH_B[j];
    for (int t = 0; t < tot; t++) begin
      c = {c[26:0], c[27]};
      d = {d[26:0], d[27]};
    end
    cd = {c, d};
    for (int i = 0; i < 48; i++) o[47 - i] = cd[56 - PC2_B[i]];
    return o;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_key(input logic [63:0] k, input logic dec);
    @(negedge clk);
    key_valid = 1'b1;
    key_data = k;
    key_decrypt = dec;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic pulse_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 rk_valid after reset", 64'(rk_valid), 64'd0);
    check("R9 key_ready after reset", 64'(key_ready), 64'd1);
    pulse_step();
    check("R7 step before any key ignored", 64'(rk_valid), 64'd0);
  endtask

  task automatic t_known_encrypt();
    logic [63:0] k = 64'h133457799BBCDFF1;
    load_key(k, 1'b0);
    check("R8 rk_valid low after load", 64'(rk_valid), 64'd0);
    pulse_step();
    check("R5 valid one clock after step", 64'(rk_valid), 64'd1);
    check("R2 round 1 vector", 64'(rk_data), 64'h1B02EFFC7072);
    check("R2 round 1 index", 64'(rk_round), 64'd0);
    pulse_step();
    check("R2 round 2 vector", 64'(rk_data), 64'h79AED9DBC9E5);
    for (int r = 3; r <= 16; r++) begin
      pulse_step();
      check("R3 encrypt schedule", 64'(rk_data), 64'(ref_rk(k, r)));
      check("R2 encrypt index", 64'(rk_round), 64'(r - 1));
    end
    pulse_step();
    check("R7 step after round 16 ignored", 64'(rk_valid), 64'd0);
  endtask

  task automatic t_decrypt(input logic [63:0] k, input bit vec);
    load_key(k, 1'b1);
    for (int r = 16; r >= 1; r--) begin
      pulse_step();
      if (vec && r == 16)
        check("R4 first decrypt vector", 64'(rk_data), 64'hCB3D8B0E17F5);
      check("R4 decrypt key", 64'(rk_data), 64'(ref_rk(k, r)));
      check("R4 decrypt index", 64'(rk_round), 64'(r - 1));
    end
    pulse_step();
    check("R7 decrypt exhausted", 64'(rk_valid), 64'd0);
  endtask

  task automatic t_parity();
    logic [63:0] k = 64'h0E329232EA6D0D73;
    load_key(k ^ 64'h0101010101010101, 1'b0);
    for (int r = 1; r <= 16; r++) begin
      pulse_step();
      check("R1 parity bits ignored", 64'(rk_data), 64'(ref_rk(k, r)));
    end
  endtask

  task automatic t_backpressure();
    logic [63:0] k = 64'hA1B2C3D4E5F60718;
    load_key(k, 1'b0);
    rk_ready = 1'b0;
    pulse_step();
    check("R6 first key presented", 64'(rk_data), 64'(ref_rk(k, 1)));
    pulse_step();
    repeat (2) @(negedge clk);
    check("R6 valid held", 64'(rk_valid), 64'd1);
    check("R6 data held", 64'(rk_data), 64'(ref_rk(k, 1)));
    check("R6 index held", 64'(rk_round), 64'd0);
    check("R6 key_ready low", 64'(key_ready), 64'd0);
    rk_ready = 1'b1;
    @(negedge clk);
    check("R6 consumed", 64'(rk_valid), 64'd0);
    pulse_step();
    check("R6 ignored step did not advance", 64'(rk_data), 64'(ref_rk(k, 2)));
    check("R6 index after release", 64'(rk_round), 64'd1);
  endtask

  task automatic t_reload();
    logic [63:0] a = 64'h0000FFFF0000FFFF;
    logic [63:0] b = 64'hFFFF0000FFFF0000;
    load_key(a, 1'b0);
    repeat (5) pulse_step();
    check("R8 progress before reload", 64'(rk_data), 64'(ref_rk(a, 5)));
    load_key(b, 1'b0);
    check("R8 valid cleared by load", 64'(rk_valid), 64'd0);
    pulse_step();
    check("R8 restart at round 1", 64'(rk_data), 64'(ref_rk(b, 1)));
    check("R8 restart index", 64'(rk_round), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known_encrypt();
    t_decrypt(64'h133457799BBCDFF1, 1'b1);
    t_decrypt(64'h00000000FFFFFFFF, 1'b0);
    t_parity();
    t_backpressure();
    t_reload();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule